// File: doc/BRIEF.md
# Widening Pairwise Add Unit with Optional Accumulate

This unit executes one small family of vector operations. Each result lane is the sum of two neighbouring source elements, taken at twice their width. The family has four variants: signed or unsigned extension, each with or without accumulation into the destination. The caller supplies three things with a single-cycle `in_valid` pulse:

- the 32-bit instruction word;
- the 128-bit source vector;
- the current 128-bit destination value.

One clock later the unit returns the new destination value with `out_valid`.

Element width comes from the two-bit size field. Bit 30 of the word selects whether the full 128-bit vector or only its low 64 bits are processed; in the narrow form the upper 64 result bits are written as zero. A word that does not belong to this family, or that uses the reserved size, raises `out_undef`. In that case the destination value passes through untouched.

Top module: `simd_pair_widen_acc`

## Requirements
- R1: A word is recognised only when bit 31 = 0, bits 28:24 = 01110, bits 21:17 = 10000 and bits 11:10 = 10; any other word raises out_undef and returns dst_in unchanged.
- R2: Bits 16:12 select the operation: 00010 is the plain pairwise widening sum, 00110 adds the pairwise sum to the destination lane; any other value raises out_undef and returns dst_in unchanged.
- R3: Bit 29 = 0 sign-extends each source element, and bit 29 = 1 zero-extends it.
- R4: A size field (bits 23:22) of 11 raises out_undef, and out_data equals dst_in.
- R5: Size 00, 01 and 10 give source elements of 8, 16 and 32 bits and result lanes of 16, 32 and 64 bits. Result lane i is built from source elements 2i and 2i+1, and lane 0 is in the least significant bits.
- R6: In the accumulating form each lane is the pairwise sum plus the destination lane, wrapping modulo 2 to the power of the lane width, with no saturation.
- R7: With bit 30 = 0, only source bits 63:0 contribute, and out_data bits 127:64 are zero; with bit 30 = 1, all 128 bits are processed.
- R8: out_valid is high exactly one cycle after a cycle with in_valid high, and out_undef and out_data are valid with it. A synchronous active-high rst clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| insn | input | 32 | Instruction word |
| src | input | 128 | Source vector |
| dst_in | input | 128 | Current destination vector |
| out_valid | output | 1 | Result present this cycle |
| out_undef | output | 1 | Undefined or reserved encoding |
| out_data | output | 128 | New destination vector |

## Verification
The bench targets the following corner cases, each of which an incorrect design would fail on:

- **Negative elements under signed extension.** A design that zero-extends them, or sign-extends unsigned ones, yields lanes that are off by a power of two.
- **Accumulation across the top of a lane.** Here the sum must wrap. A carry that leaks into the next lane, or a sum that saturates, corrupts the neighbour or clamps the value.
- **The narrow form with a non-zero destination upper half.** A design that forgets to zero the upper half shows stale bits there.
- **Reserved size, foreign opcodes and wrong fixed bits.** A design that mishandles these would either compute a result or fail to pass the destination through.

Random encodings across every size are also compared against a behavioural model, which catches any lane-order or pairing slip.

// File: rtl/simd_pair_widen_acc.sv
module simd_pair_widen_acc #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] src,
  input  logic [VLEN-1:0] dst_in,
  output logic            out_valid,
  output logic            out_undef,
  output logic [VLEN-1:0] out_data
);
  localparam int HALF = VLEN / 2;

  logic       wide, zext, is_acc, undef;
  logic [1:0] sz;
  logic [VLEN-1:0] result, picked;

  assign wide = insn[30];
  assign zext = insn[29];
  assign sz   = insn[23:22];

  wire fixed_ok = (insn[31] == 1'b0) && (insn[28:24] == 5'b01110) &&
                  (insn[21:17] == 5'b10000) && (insn[11:10] == 2'b10);
  wire op_plain = insn[16:12] == 5'b00010;
  assign is_acc = insn[16:12] == 5'b00110;
  assign undef  = !fixed_ok || !(op_plain || is_acc) || (sz == 2'b11);

  wire [VLEN-1:0] by_size [3];

  for (genvar s = 0; s < 3; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int LW = 2 * EW;
    localparam int NL = VLEN / LW;
    wire [VLEN-1:0] lanes;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      wire [EW-1:0] ea = src[(2*i)*EW +: EW];
      wire [EW-1:0] eb = src[(2*i+1)*EW +: EW];
      wire [LW-1:0] xa = {{EW{!zext & ea[EW-1]}}, ea};
      wire [LW-1:0] xb = {{EW{!zext & eb[EW-1]}}, eb};
      wire [LW-1:0] acc = is_acc ? dst_in[i*LW +: LW] : '0;
      assign lanes[i*LW +: LW] = xa + xb + acc;
    end
    assign by_size[s] = lanes;
  end

  always_comb begin
    case (sz)
      2'b00:   picked = by_size[0];
      2'b01:   picked = by_size[1];
      default: picked = by_size[2];
    endcase
    result = wide ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_undef <= undef;
        out_data  <= undef ? dst_in : result;
      end
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && !$past(rst)));

  assert_reserved_size_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(insn[23:22]) == 2'b11) |-> out_undef);

  assert_undef_keeps_dst_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_data == $past(dst_in)));

  assert_bad_opcode_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(insn[16:12]) != 5'b00010 && $past(insn[16:12]) != 5'b00110)
      |-> out_undef);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_undef && !$past(insn[30])) |-> (out_data[VLEN-1:HALF] == '0));
endmodule

// File: tb/simd_pair_widen_acc_tb.sv
module simd_pair_widen_acc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [127:0] src = '0, dst_in = '0;
  logic out_valid, out_undef;
  logic [127:0] out_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  simd_pair_widen_acc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .src(src),
    .dst_in(dst_in), .out_valid(out_valid), .out_undef(out_undef), .out_data(out_data)
  );

  function automatic logic [31:0] enc(bit q, bit u, logic [1:0] sz, bit acc);
    enc = {1'b0, q, u, 5'b01110, sz, 5'b10000, acc ? 5'b00110 : 5'b00010, 2'b10, 5'd3, 5'd7};
  endfunction

  function automatic logic [127:0] msk(int n);
    msk = (n >= 128) ? {128{1'b1}} : ((128'd1 << n) - 128'd1);
  endfunction

  task automatic model(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d,
                       output logic [127:0] r, output bit und);
    int ew, nl;
    logic [127:0] a, b, sum;
    und = (w[31] != 0) || (w[28:24] != 5'b01110) || (w[21:17] != 5'b10000) ||
          (w[11:10] != 2'b10) || (w[16:12] != 5'b00010 && w[16:12] != 5'b00110) ||
          (w[23:22] == 2'b11);
    if (und) begin r = d; return; end
    ew = 8 << w[23:22];
    nl = (w[30] ? 128 : 64) / (2 * ew);
    r = '0;
    for (int i = 0; i < nl; i++) begin
      a = (s >> (2 * i * ew)) & msk(ew);
      b = (s >> ((2 * i + 1) * ew)) & msk(ew);
      if (!w[29] && a[ew-1]) a = a | ~msk(ew);
      if (!w[29] && b[ew-1]) b = b | ~msk(ew);
      sum = a + b;
      if (w[16:12] == 5'b00110) sum = sum + ((d >> (i * 2 * ew)) & msk(2 * ew));
      r = r | ((sum & msk(2 * ew)) << (i * 2 * ew));
    end
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input bit v, input logic [31:0] w,
                     input logic [127:0] s, input logic [127:0] d);
    logic [127:0] er;
    bit eu;
    in_valid = v; insn = w; src = s; dst_in = d;
    model(w, s, d, er, eu);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check({tag, " R8 out_valid"}, {127'd0, out_valid}, {127'd0, v});
    if (v) begin
      check({tag, " undef"}, {127'd0, out_undef}, {127'd0, eu});
      check({tag, " data"}, out_data, er);
    end
  endtask

  function automatic logic [127:0] rnd128();
    rnd128 = {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R8 reset out_valid", {127'd0, out_valid}, 128'd0);
    run("R5 R3 unsigned bytes", 1, enc(1, 1, 2'b00, 0), {16{8'hFF}}, '0);
    run("R3 signed bytes", 1, enc(1, 0, 2'b00, 0), {16{8'hFF}}, '0);
    run("R5 lane order halves", 1, enc(1, 1, 2'b01, 0),
        128'h0008_0007_0006_0005_0004_0003_0002_0001, '0);
    run("R5 R3 signed words", 1, enc(1, 0, 2'b10, 0),
        128'h8000_0000_8000_0000_7FFF_FFFF_0000_0001, '0);
    run("R6 accumulate wrap", 1, enc(1, 1, 2'b00, 1), {16{8'h01}}, {8{16'hFFFF}});
    run("R6 signed acc 64", 1, enc(1, 0, 2'b10, 1), {4{32'hFFFF_FFFF}},
        {2{64'h0000_0000_0000_0001}});
    run("R7 narrow zero upper", 1, enc(0, 1, 2'b01, 1), rnd128(), {128{1'b1}});
    run("R4 reserved size", 1, enc(1, 1, 2'b11, 1), rnd128(), rnd128());
    w = enc(1, 1, 2'b00, 0); w[16:12] = 5'b00100;
    run("R2 foreign opcode", 1, w, rnd128(), rnd128());
    w = enc(1, 1, 2'b00, 0); w[31] = 1'b1;
    run("R1 bad fixed bit31", 1, w, rnd128(), rnd128());
    w = enc(1, 1, 2'b00, 0); w[11:10] = 2'b00;
    run("R1 bad fixed bits11_10", 1, w, rnd128(), rnd128());
    run("R8 idle", 0, enc(1, 1, 2'b00, 0), rnd128(), rnd128());
    for (int k = 0; k < 400; k++) begin
      w = enc($urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom_range(0, 3)),
              $urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) w[16:12] = 5'($urandom);
      run("R5 R6 R7 random", $urandom_range(0, 5) != 0, w, rnd128(), rnd128());
    end
    in_valid = 1'b1; insn = enc(1, 1, 2'b00, 0); rst = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R8 reset clears out_valid", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule